// File: doc/BRIEF.md
# Three-Source Maskable Interrupt Flag Unit

This unit gathers three single-cycle event pulses from a real-time clock core (alarm match, periodic tick, end of update cycle) into latched pending flags. The flags are reported in a read-only status byte. A control byte holds one enable per source plus a square-wave enable. When any pending flag has its enable set, the unit asks for an open-drain request line to be pulled low. A summary bit in the status byte reports the same condition.

The host reaches both bytes through a simple selected register port. A read of the status byte returns the flags and clears them as a side effect, which releases the request line. A synchronous active-low reset clears all flags, all enables and the square-wave enable, and floats the request line while it is held. The request output is an enable for an external open-drain driver, and `irq_line` models the wire as seen with a pull-up.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: After reset the status byte and the control byte both read 0x00, `sqw_en` is 0 and `irq_line` reads 1.
- R2: An event pulse sets its pending flag whether or not the matching enable is set. In the status byte, bit 6 is the periodic flag, bit 5 is the alarm flag and bit 4 is the update flag.
- R3: Status bit 7 (summary) is 1 exactly when some pending flag has its enable set. A flag whose enable is clear leaves bit 7 at 0 and leaves `irq_line` at 1.
- R4: `irq_pull_low` is 1, and `irq_line` reads 0, from the cycle after a pulse sets an enabled flag. They stay that way while any enabled flag is pending, and `irq_line` reads 1 whenever the line is released.
- R5: A selected read of the status byte returns the flags as they were before the read and clears all three flags, so the line is released in the following cycle.
- R6: An event pulse in the same cycle as a status read is not lost. The read returns the earlier flags and that event's flag remains set afterwards.
- R7: Control byte bit 6 enables the periodic source, bit 5 the alarm source, bit 4 the update source, and bit 3 drives `sqw_en`. Bits 7 and 2 to 0 read as 0 whatever was written.
- R8: The status byte is read-only: a write to it leaves the flags unchanged. Its bits 3 to 0 always read as 0.
- R9: A read or write with `bus_sel` low changes no flag, no enable and no read data.
- R10: Holding `rst_n` low clears pending flags and all enables including `sqw_en`, and `irq_line` reads 1 while reset is held, even if an enabled flag was pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Register port select |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after the read strobe |
| alarm_evt | input | 1 | Alarm match pulse |
| periodic_evt | input | 1 | Periodic tick pulse |
| update_evt | input | 1 | Update-ended pulse |
| sqw_en | output | 1 | Square-wave enable bit |
| irq_pull_low | output | 1 | Enable of the open-drain pull-down |
| irq_line | output | 1 | Modelled request wire (0 pulled, 1 released) |

## Verification
The bench uses the default parameters: a 7-bit address, with the control byte at 0x0B and the status byte at 0x0C. This puts both bytes next to each other inside one address window, so a wrong address decode lands on a real neighbour rather than on empty space. With these values the bench can exercise masked and unmasked sources, a summary bit without a request, and the same-cycle race between an event and the clearing read. It also covers writes to the read-only byte, unselected strobes, and a reset asserted while a request is active.

// File: rtl/rtc_irq_pkg.sv
// Shared constants and types for the interrupt flag unit.
// Source index i maps to status bit SRC_BIT_BASE+i and to control bit SRC_BIT_BASE+i.
package rtc_irq_pkg;
    localparam int NUM_SRC      = 3;
    localparam int SRC_BIT_BASE = 4;   // index 0 update, 1 alarm, 2 periodic
    localparam int SUM_BIT      = 7;   // summary bit in status byte
    localparam int SQW_BIT      = 3;   // square-wave enable in control byte
    localparam int SRC_UPD      = 0;
    localparam int SRC_ALM      = 1;
    localparam int SRC_PER      = 2;
    typedef logic [NUM_SRC-1:0] src_vec_t;
endpackage

// File: rtl/rtc_irq_flag.sv
// One pending flag: set by an event pulse, cleared by a status read.
// Assumes evt and clr are single-cycle strobes; set wins over clear.
module rtc_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic clr,
    output logic flag_q
);
    // Latch the event, drop it on a clearing read unless an event coincides
    always_ff @(posedge clk) begin
        if (!rst_n)   flag_q <= 1'b0;
        else if (evt) flag_q <= 1'b1;
        else if (clr) flag_q <= 1'b0;
    end

    // R2
    evt_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> flag_q);
    // R5
    clr_drops_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !evt) |=> !flag_q);
endmodule

// File: rtl/rtc_irq_regs.sv
// Register port: control byte (enables, square-wave enable) and read-only status byte.
// Assumes a strobe is honoured only with sel high; read data is registered.
module rtc_irq_regs
    import rtc_irq_pkg::*;
#(
    parameter int ADDR_W     = 7,
    parameter int CTRL_ADDR  = 11,
    parameter int STAT_ADDR  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr,
    input  logic              rd,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  src_vec_t          flags,
    input  logic              summary,
    output src_vec_t          en_q,
    output logic              sqw_q,
    output logic              stat_rd,
    output logic              ctrl_wr,
    output logic [7:0]        rdata_q
);
    localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);
    localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);

    logic       ctrl_rd;
    logic [7:0] ctrl_view;
    logic [7:0] stat_view;

    // Decode selected strobes per register
    always_comb begin
        ctrl_wr = sel && wr && (addr == CTRL_A);
        ctrl_rd = sel && rd && (addr == CTRL_A);
        stat_rd = sel && rd && (addr == STAT_A);
    end

    // Assemble the readable images of both bytes
    always_comb begin
        ctrl_view = 8'h00;
        stat_view = 8'h00;
        ctrl_view[SQW_BIT] = sqw_q;
        stat_view[SUM_BIT] = summary;
        for (int i = 0; i < NUM_SRC; i++) begin
            ctrl_view[SRC_BIT_BASE+i] = en_q[i];
            stat_view[SRC_BIT_BASE+i] = flags[i];
        end
    end

    // Hold the control fields written by the host
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= '0;
            sqw_q <= 1'b0;
        end else if (ctrl_wr) begin
            en_q  <= wdata[SRC_BIT_BASE +: NUM_SRC];
            sqw_q <= wdata[SQW_BIT];
        end
    end

    // Capture read data for the cycle after a selected read
    always_ff @(posedge clk) begin
        if (!rst_n)        rdata_q <= 8'h00;
        else if (stat_rd)  rdata_q <= stat_view;
        else if (ctrl_rd)  rdata_q <= ctrl_view;
        else if (sel && rd) rdata_q <= 8'h00;
    end

    // R7
    sqw_follows_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_wr |=> (sqw_q == $past(wdata[SQW_BIT])));
    // R8
    stat_low_nibble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd |=> (rdata_q[3:0] == 4'h0));
endmodule

// File: rtl/rtc_irq_ctrl.sv
// Top: three maskable interrupt sources with read-to-clear status and an
// open-drain request. Assumes event inputs are single-cycle pulses in clk.
module rtc_irq_ctrl
    import rtc_irq_pkg::*;
#(
    parameter int ADDR_W    = 7,
    parameter int CTRL_ADDR = 11,
    parameter int STAT_ADDR = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              alarm_evt,
    input  logic              periodic_evt,
    input  logic              update_evt,
    output logic              sqw_en,
    output logic              irq_pull_low,
    output logic              irq_line
);
    src_vec_t evts;
    src_vec_t flags;
    src_vec_t en;
    logic     summary;
    logic     stat_rd;
    logic     ctrl_wr;

    // Gather event pulses in source-index order
    always_comb begin
        evts          = '0;
        evts[SRC_UPD] = update_evt;
        evts[SRC_ALM] = alarm_evt;
        evts[SRC_PER] = periodic_evt;
    end

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        rtc_irq_flag u_flag (
            .clk    (clk),
            .rst_n  (rst_n),
            .evt    (evts[i]),
            .clr    (stat_rd),
            .flag_q (flags[i])
        );
    end

    rtc_irq_regs #(
        .ADDR_W    (ADDR_W),
        .CTRL_ADDR (CTRL_ADDR),
        .STAT_ADDR (STAT_ADDR)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (bus_sel),
        .wr      (bus_wr),
        .rd      (bus_rd),
        .addr    (bus_addr),
        .wdata   (bus_wdata),
        .flags   (flags),
        .summary (summary),
        .en_q    (en),
        .sqw_q   (sqw_en),
        .stat_rd (stat_rd),
        .ctrl_wr (ctrl_wr),
        .rdata_q (bus_rdata)
    );

    // Summary and open-drain request, released while reset is held
    always_comb begin
        summary      = |(flags & en);
        irq_pull_low = rst_n && summary;
        irq_line     = !irq_pull_low;
    end

    // R4
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_pull_low) |-> ($past(|evts) || $past(ctrl_wr)));
    // R5
    irq_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_rd && !(|evts)) |=> !irq_pull_low);
endmodule

// File: tb/rtc_irq_ctrl_bench.sv
module rtc_irq_ctrl_bench;
    localparam int  AW  = 7;
    localparam logic [AW-1:0] A_CTRL = 7'h0B;
    localparam logic [AW-1:0] A_STAT = 7'h0C;
    localparam int  K_RD  = 0;
    localparam int  K_IRQ = 1;
    localparam int  K_SQW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [7:0]    bus_wdata = 8'h00;
    logic [7:0]    bus_rdata;
    logic          alarm_evt = 1'b0, periodic_evt = 1'b0, update_evt = 1'b0;
    logic          sqw_en, irq_pull_low, irq_line;

    int  cyc = 0;
    int  n_run = 0;
    int  n_fail = 0;
    bit  done = 1'b0;

    typedef struct {
        int         due;
        int         kind;
        logic [7:0] exp;
        string      req;
    } item_t;
    item_t sb[$];

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    rtc_irq_ctrl u_rtc_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .alarm_evt(alarm_evt),
        .periodic_evt(periodic_evt), .update_evt(update_evt),
        .sqw_en(sqw_en), .irq_pull_low(irq_pull_low), .irq_line(irq_line)
    );

    // Monitor: pops due items and compares against the ports
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb.size() > 0 && sb[0].due <= cyc) begin
                item_t it;
                logic [7:0] act;
                it = sb.pop_front();
                case (it.kind)
                    K_RD:    act = bus_rdata;
                    K_IRQ:   act = {7'h0, irq_line};
                    default: act = {7'h0, sqw_en};
                endcase
                n_run++;
                if (act !== it.exp) begin
                    n_fail++;
                    $display("FAIL %s: actual %02h expected %02h", it.req, act, it.exp);
                end
            end
        end
    end

    task automatic push(input int due, input int kind, input logic [7:0] exp, input string req);
        item_t it;
        it.due = due; it.kind = kind; it.exp = exp; it.req = req;
        sb.push_back(it);
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic idle_bus();
        bus_sel = 1'b0; bus_wr = 1'b0; bus_rd = 1'b0;
        alarm_evt = 1'b0; periodic_evt = 1'b0; update_evt = 1'b0;
    endtask

    task automatic rd_reg(input logic [AW-1:0] a, input logic [7:0] exp, input string req);
        bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = a;
        push(cyc + 1, K_RD, exp, req);
        step();
        idle_bus();
    endtask

    task automatic wr_reg(input logic [AW-1:0] a, input logic [7:0] d, input logic s);
        bus_sel = s; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        step();
        idle_bus();
    endtask

    task automatic pulse(input logic alm, input logic per, input logic upd);
        alarm_evt = alm; periodic_evt = per; update_evt = upd;
        step();
        idle_bus();
    endtask

    task automatic chk_now(input int kind, input logic [7:0] exp, input string req);
        push(cyc, kind, exp, req);
        step();
    endtask

    // Watchdog
    initial begin
        #200000;
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    // Driver
    initial begin
        idle_bus();
        repeat (3) step();
        rst_n = 1'b1;
        step();
        // R1 reset state
        rd_reg(A_CTRL, 8'h00, "R1 ctrl after reset");
        rd_reg(A_STAT, 8'h00, "R1 status after reset");
        chk_now(K_IRQ, 8'h01, "R1 line released");
        chk_now(K_SQW, 8'h00, "R1 sqw_en clear");

        // R2 / R3 masked source still flags, no summary, no request
        pulse(1'b1, 1'b0, 1'b0);
        chk_now(K_IRQ, 8'h01, "R3 masked flag leaves line high");
        rd_reg(A_STAT, 8'h20, "R2 alarm flag with enable clear");
        rd_reg(A_STAT, 8'h00, "R5 read cleared flags");

        // R7 control fields
        wr_reg(A_CTRL, 8'h78, 1'b1);
        rd_reg(A_CTRL, 8'h78, "R7 enables and sqw read back");
        chk_now(K_SQW, 8'h01, "R7 sqw_en set");
        wr_reg(A_CTRL, 8'hFF, 1'b1);
        rd_reg(A_CTRL, 8'h78, "R7 unused bits read zero");

        // R4 / R3 enabled periodic source
        pulse(1'b0, 1'b1, 1'b0);
        chk_now(K_IRQ, 8'h00, "R4 line pulled after enabled event");
        rd_reg(A_STAT, 8'hC0, "R3 summary with periodic flag");
        chk_now(K_IRQ, 8'h01, "R5 line released after read");
        rd_reg(A_STAT, 8'h00, "R5 flags empty");

        // R3 only update enabled
        wr_reg(A_CTRL, 8'h10, 1'b1);
        pulse(1'b1, 1'b0, 1'b0);
        chk_now(K_IRQ, 8'h01, "R3 alarm masked no request");
        pulse(1'b0, 1'b0, 1'b1);
        chk_now(K_IRQ, 8'h00, "R4 update enabled pulls line");
        chk_now(K_IRQ, 8'h00, "R4 line held while pending");
        rd_reg(A_STAT, 8'hB0, "R3 summary with alarm and update");

        // R6 event coinciding with clearing read
        wr_reg(A_CTRL, 8'h40, 1'b1);
        pulse(1'b0, 1'b0, 1'b1);
        chk_now(K_IRQ, 8'h01, "R3 update masked");
        periodic_evt = 1'b1;
        rd_reg(A_STAT, 8'h10, "R6 read returns earlier flags");
        chk_now(K_IRQ, 8'h00, "R6 coinciding event kept");
        rd_reg(A_STAT, 8'hC0, "R6 periodic flag survived read");

        // R8 write to status ignored
        wr_reg(A_CTRL, 8'h20, 1'b1);
        pulse(1'b1, 1'b0, 1'b0);
        wr_reg(A_STAT, 8'h00, 1'b1);
        chk_now(K_IRQ, 8'h00, "R8 write to status kept request");
        rd_reg(A_STAT, 8'hA0, "R8 flags unchanged by write");

        // R9 unselected accesses
        pulse(1'b1, 1'b0, 1'b0);
        bus_rd = 1'b1; bus_addr = A_STAT;
        step();
        idle_bus();
        chk_now(K_IRQ, 8'h00, "R9 unselected read kept flags");
        chk_now(K_RD, 8'hA0, "R9 unselected read kept rdata");
        wr_reg(A_CTRL, 8'h00, 1'b0);
        chk_now(K_IRQ, 8'h00, "R9 unselected write kept enables");
        rd_reg(A_CTRL, 8'h20, "R9 control unchanged");

        // R10 reset while request active
        wr_reg(A_CTRL, 8'h28, 1'b1);
        chk_now(K_IRQ, 8'h00, "R10 request active before reset");
        rst_n = 1'b0;
        chk_now(K_IRQ, 8'h01, "R10 line floats during reset");
        step();
        chk_now(K_SQW, 8'h00, "R10 sqw_en cleared");
        rst_n = 1'b1;
        step();
        rd_reg(A_CTRL, 8'h00, "R10 enables cleared");
        rd_reg(A_STAT, 8'h00, "R10 flags cleared");
        chk_now(K_IRQ, 8'h01, "R10 line released after reset");

        repeat (3) step();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule